// File: doc/BRIEF.md
# Cycle-Stealing Block Transfer Controller

This block moves a block of words between one I/O device and main memory so that the processor never handles the data itself. Software loads a direction, a device address, a memory start address and a word count into a small register file, then sets a start bit. From then on the controller works alone until the whole block has been moved.

For every word the controller first waits for the device to signal that it is ready. It then asks for the shared bus and performs one memory access once the bus is granted. It gives the bus back straight away, so the processor is held off for a single bus cycle per word and never takes an interrupt for it. Each word crosses the bus once, between the controller and memory. The memory address steps up by one and the count steps down by one after each word. When the count reaches zero the controller sets a done flag and raises its interrupt line, which stays high until software clears the flag.

Top module: `dma_steal_ctrl`

## Requirements
- R1: After reset, busReq, memEn, devWrEn and irq are low, and the status register (index 4) reads 0 (bit 0 busy, bit 1 done).
- R2: While idle, writes to the device address (index 1), memory address (index 2) and count (index 3) registers read back unchanged. The control register (index 0) reads the direction in bit 1 (1 = memory to device, 0 = device to memory) and reads 0 in bit 0.
- R3: While busy, writes to the control, device address, memory address and count registers have no effect.
- R4: busReq does not rise for a word until devReady has been seen for that word.
- R5: busReq stays high until busGnt is seen. Exactly one memory cycle (memEn) follows in the next clock, and busReq is low in the clock after that cycle.
- R6: Device to memory: the word present on devRdData while devReady is high is written (memWe high) to memory. Consecutive words go to start, start+1, and so on.
- R7: Memory to device: memory is only read (memWe low), and each word read is presented on devWrData with a one-clock devWrEn pulse in the clock after its memory cycle.
- R8: After N words the controller stops, with busy 0, done 1 and irq high. The count register then reads 0 and the memory address register reads start+N.
- R9: A start with a count of 0 sets done and irq in the next clock and makes no bus request.
- R10: Writing the status register with bit 1 set clears done and irq. A status write with bit 1 clear leaves them unchanged.
- R11: A start written while a transfer is busy is ignored; the running transfer moves exactly its programmed word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register index |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data (combinational) |
| irq | output | 1 | Completion interrupt, level |
| busReq | output | 1 | Bus request |
| busGnt | input | 1 | Bus grant |
| memEn | output | 1 | Memory cycle enable |
| memWe | output | 1 | Memory write (1) or read (0) |
| memAddr | output | 16 | Memory address |
| memWrData | output | 16 | Memory write data |
| memRdData | input | 16 | Memory read data, valid in the memory cycle |
| devReady | input | 1 | Device ready for the next word |
| devAddr | output | 16 | Device address |
| devRdData | input | 16 | Word from the device |
| devWrData | output | 16 | Word to the device |
| devWrEn | output | 1 | Device write pulse |

## Verification
The assertions check the bus handshake on every cycle: a memory cycle happens only after a granted request, the request drops right after each memory cycle, and a request rises only after the device is ready. They also check that each word steps the address up by one and the count down by one, that busy and done are never set together, and that a zero-count start completes at once. The bench scenarios cover the parts that need a memory model and a timeline: the values that end up in memory or at the device, the final register contents, the start and register writes ignored while busy, and the way the done flag is cleared.

// File: rtl/dma_steal_pkg.sv
package dma_steal_pkg;
  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] REG_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] REG_DEV  = 3'd1;
  localparam logic [REG_AW-1:0] REG_MEM  = 3'd2;
  localparam logic [REG_AW-1:0] REG_CNT  = 3'd3;
  localparam logic [REG_AW-1:0] REG_STAT = 3'd4;

  typedef struct packed {
    logic lock;    // configuration frozen while a transfer runs
    logic capDev;  // latch the device word into the buffer
    logic capMem;  // latch the memory word into the buffer
    logic step;    // advance address, decrement count
  } dmaStrobes_t;
endpackage

// File: rtl/dma_steal_datapath.sv
module dma_steal_datapath
  import dma_steal_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int DEV_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobes_t       st,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              statBusy,
  input  logic              statDone,
  input  logic [DATA_W-1:0] devRdData,
  input  logic [DATA_W-1:0] memRdData,
  output logic              dirToDev,
  output logic              countZero,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DEV_W-1:0]  devAddr,
  output logic [DATA_W-1:0] bufWord
);
  logic [CNT_W-1:0] countReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirToDev <= 1'b0;
      devAddr  <= '0;
      memAddr  <= '0;
      countReg <= '0;
      bufWord  <= '0;
    end else begin
      if (!st.lock && regWrEn) begin
        unique case (regAddr)
          REG_CTRL: dirToDev <= regWrData[1];
          REG_DEV:  devAddr  <= DEV_W'(regWrData);
          REG_MEM:  memAddr  <= ADDR_W'(regWrData);
          REG_CNT:  countReg <= CNT_W'(regWrData);
          default: ;
        endcase
      end
      if (st.step) begin
        memAddr  <= memAddr + 1'b1;
        countReg <= countReg - 1'b1;
      end
      if (st.capDev) bufWord <= devRdData;
      if (st.capMem) bufWord <= memRdData;
    end
  end

  assign countZero = (countReg == '0);

  always_comb begin
    unique case (regAddr)
      REG_CTRL: regRdData = DATA_W'({dirToDev, 1'b0});
      REG_DEV:  regRdData = DATA_W'(devAddr);
      REG_MEM:  regRdData = DATA_W'(memAddr);
      REG_CNT:  regRdData = DATA_W'(countReg);
      REG_STAT: regRdData = DATA_W'({statDone, statBusy});
      default:  regRdData = '0;
    endcase
  end

  // R8: every word decrements the count by one
  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    st.step |=> countReg == $past(countReg) - 1'b1);
  // R6: every word advances the memory address by one
  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    st.step |=> memAddr == $past(memAddr) + 1'b1);
  // R3: no configuration change while locked, other than stepping
  assert_dev_frozen_R3: assert property (@(posedge clk) disable iff (!rstN)
    (st.lock && $past(st.lock)) |-> $stable(devAddr) && $stable(dirToDev));
endmodule

// File: rtl/dma_steal_control.sv
module dma_steal_control
  import dma_steal_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              dirToDev,
  input  logic              countZero,
  input  logic              devReady,
  input  logic              busGnt,
  output dmaStrobes_t       st,
  output logic              busReq,
  output logic              memEn,
  output logic              memWe,
  output logic              devWrEn,
  output logic              busy,
  output logic              done
);
  typedef enum logic [2:0] {S_IDLE, S_WAITDEV, S_REQ, S_XFER, S_GAP} state_t;
  state_t state, nextState;

  logic startGo, clearDone, finish;
  assign startGo   = regWrEn && regAddr == REG_CTRL && regWrData[0] && state == S_IDLE;
  assign clearDone = regWrEn && regAddr == REG_STAT && regWrData[1];
  assign finish    = state == S_GAP && countZero;

  always_comb begin
    nextState = state;
    unique case (state)
      S_IDLE:    if (startGo && !countZero) nextState = S_WAITDEV;
      S_WAITDEV: if (devReady) nextState = S_REQ;
      S_REQ:     if (busGnt) nextState = S_XFER;
      S_XFER:    nextState = S_GAP;
      S_GAP:     nextState = countZero ? S_IDLE : S_WAITDEV;
      default:   nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      if (startGo)        done <= countZero;
      else if (finish)    done <= 1'b1;
      else if (clearDone) done <= 1'b0;
    end
  end

  always_comb begin
    st.lock   = state != S_IDLE;
    st.capDev = state == S_WAITDEV && devReady && !dirToDev;
    st.capMem = state == S_XFER && dirToDev;
    st.step   = state == S_XFER;
  end

  assign busy    = state != S_IDLE;
  assign busReq  = state == S_REQ || state == S_XFER;
  assign memEn   = state == S_XFER;
  assign memWe   = state == S_XFER && !dirToDev;
  assign devWrEn = state == S_GAP && dirToDev;

  // R5: a memory cycle only follows a granted request
  assert_mem_after_grant_R5: assert property (@(posedge clk) disable iff (!rstN)
    memEn |-> $past(busReq) && $past(busGnt));
  // R5: the bus is released right after each memory cycle
  assert_release_after_cycle_R5: assert property (@(posedge clk) disable iff (!rstN)
    memEn |=> !busReq);
  // R4: a request rises only after the device is ready
  assert_req_after_ready_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) |-> $past(devReady));
  // R8: busy and done are never set together
  assert_busy_done_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));
  // R9: a zero-count start completes in the next clock
  assert_zero_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    (startGo && countZero) |=> done && !busy);
endmodule

// File: rtl/dma_steal_ctrl.sv
module dma_steal_ctrl
  import dma_steal_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int DEV_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irq,
  output logic              busReq,
  input  logic              busGnt,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              devReady,
  output logic [DEV_W-1:0]  devAddr,
  input  logic [DATA_W-1:0] devRdData,
  output logic [DATA_W-1:0] devWrData,
  output logic              devWrEn
);
  dmaStrobes_t       st;
  logic              dirToDev, countZero, busy, done;
  logic [DATA_W-1:0] bufWord;

  dma_steal_control #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .dirToDev(dirToDev), .countZero(countZero),
    .devReady(devReady), .busGnt(busGnt), .st(st), .busReq(busReq),
    .memEn(memEn), .memWe(memWe), .devWrEn(devWrEn), .busy(busy), .done(done)
  );

  dma_steal_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEV_W(DEV_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .statBusy(busy), .statDone(done),
    .devRdData(devRdData), .memRdData(memRdData), .dirToDev(dirToDev),
    .countZero(countZero), .memAddr(memAddr), .devAddr(devAddr), .bufWord(bufWord)
  );

  assign irq       = done;
  assign memWrData = bufWord;
  assign devWrData = bufWord;
endmodule

// File: tb/dma_steal_ctrl_test.sv
module dma_steal_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int GNT_DELAY  = 2;

  logic        clk = 0, rstN = 0;
  logic        regWrEn = 0;
  logic [2:0]  regAddr = 0;
  logic [15:0] regWrData = 0, regRdData;
  logic        irq, busReq, busGnt = 0, memEn, memWe, devWrEn;
  logic        devReady = 0;
  logic [15:0] memAddr, memWrData, memRdData, devAddr, devWrData;
  logic [15:0] devRdData = 16'hA000;

  logic [15:0] mem [16];
  logic [15:0] devGot [8];
  int devGotN = 0, memCnt = 0, memWrCnt = 0, reqRise = 0, gapErr = 0, gntCnt = 0;
  logic prevMemEn = 0, prevReq = 0;
  int nChecks = 0, nFails = 0, cycles = 0;

  dma_steal_ctrl uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irq(irq), .busReq(busReq),
    .busGnt(busGnt), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWrData(memWrData), .memRdData(memRdData), .devReady(devReady),
    .devAddr(devAddr), .devRdData(devRdData), .devWrData(devWrData), .devWrEn(devWrEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  assign memRdData = mem[memAddr[3:0]];

  // memory stub, arbiter, device model and bus monitor, all on the falling edge
  always @(negedge clk) begin
    cycles++;
    if (prevMemEn && busReq) gapErr++;
    if (busReq && !prevReq) reqRise++;
    if (memEn) begin
      memCnt++;
      if (memWe) begin
        memWrCnt++;
        mem[memAddr[3:0]] = memWrData;
      end
      devRdData = devRdData + 16'd1;
    end
    if (devWrEn && devGotN < 8) begin
      devGot[devGotN] = devWrData;
      devGotN++;
    end
    prevMemEn = memEn;
    prevReq   = busReq;
    if (busReq) begin
      gntCnt++;
      busGnt = (gntCnt >= GNT_DELAY);
    end else begin
      gntCnt = 0;
      busGnt = 0;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [15:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitIrq();
    for (int i = 0; i < 400 && !irq; i++) @(negedge clk);
  endtask

  task automatic clearCounters();
    memCnt = 0; memWrCnt = 0; reqRise = 0; gapErr = 0; devGotN = 0;
  endtask

  task automatic testReset();
    logic [15:0] v;
    rdReg(3'd4, v);
    check(v == 0, "R1 status", v, 0);
    check(!busReq && !memEn && !devWrEn && !irq, "R1 outputs",
          {busReq, memEn, devWrEn, irq}, 0);
  endtask

  task automatic testReadback();
    logic [15:0] v;
    wrReg(3'd1, 16'h0123); wrReg(3'd2, 16'h0456); wrReg(3'd3, 16'h0009);
    wrReg(3'd0, 16'h0002);
    rdReg(3'd1, v); check(v == 16'h0123, "R2 dev addr", v, 16'h0123);
    rdReg(3'd2, v); check(v == 16'h0456, "R2 mem addr", v, 16'h0456);
    rdReg(3'd3, v); check(v == 16'h0009, "R2 count", v, 16'h0009);
    rdReg(3'd0, v); check(v == 16'h0002, "R2 ctrl", v, 16'h0002);
  endtask

  task automatic testDevToMem();
    logic [15:0] v;
    clearCounters();
    devRdData = 16'hA000; devReady = 0;
    wrReg(3'd1, 16'h0005); wrReg(3'd2, 16'h0003); wrReg(3'd3, 16'h0004);
    wrReg(3'd0, 16'h0001);
    repeat (6) @(negedge clk);
    check(reqRise == 0 && !busReq, "R4 no request before ready", reqRise, 0);
    devReady = 1;
    waitIrq();
    devReady = 0;
    for (int k = 0; k < 4; k++)
      check(mem[3+k] == 16'hA000 + 16'(k), "R6 word written", mem[3+k], 16'hA000 + k);
    check(memWrCnt == 4, "R6 writes", memWrCnt, 4);
    check(reqRise == 4 && memCnt == 4, "R5 one cycle per grant", {reqRise[15:0], memCnt[15:0]}, 32'h00040004);
    check(gapErr == 0, "R5 release after cycle", gapErr, 0);
    check(irq == 1, "R8 irq", irq, 1);
    rdReg(3'd4, v); check(v == 16'h0002, "R8 status", v, 2);
    rdReg(3'd3, v); check(v == 0, "R8 count", v, 0);
    rdReg(3'd2, v); check(v == 16'h0007, "R8 mem addr", v, 7);
    check(devAddr == 16'h0005, "R2 devAddr port", devAddr, 5);
  endtask

  task automatic testDoneClear();
    logic [15:0] v;
    wrReg(3'd4, 16'h0000);
    check(irq == 1, "R10 write without bit1 keeps irq", irq, 1);
    wrReg(3'd4, 16'h0002);
    check(irq == 0, "R10 clear irq", irq, 0);
    rdReg(3'd4, v); check(v == 0, "R10 status", v, 0);
  endtask

  task automatic testMemToDev();
    clearCounters();
    mem[8] = 16'h1111; mem[9] = 16'h2222; mem[10] = 16'h3333;
    devReady = 1;
    wrReg(3'd2, 16'h0008); wrReg(3'd3, 16'h0003); wrReg(3'd0, 16'h0003);
    waitIrq();
    devReady = 0;
    check(devGotN == 3, "R7 device writes", devGotN, 3);
    check(devGot[0] == 16'h1111, "R7 word0", devGot[0], 16'h1111);
    check(devGot[1] == 16'h2222, "R7 word1", devGot[1], 16'h2222);
    check(devGot[2] == 16'h3333, "R7 word2", devGot[2], 16'h3333);
    check(memWrCnt == 0 && memCnt == 3, "R7 reads only", memWrCnt, 0);
    wrReg(3'd4, 16'h0002);
  endtask

  task automatic testLockWhileBusy();
    logic [15:0] v;
    clearCounters();
    devReady = 0;
    wrReg(3'd1, 16'h0011); wrReg(3'd2, 16'h000C); wrReg(3'd3, 16'h0002);
    wrReg(3'd0, 16'h0001);
    wrReg(3'd1, 16'h0077);
    wrReg(3'd0, 16'h0003);
    wrReg(3'd3, 16'h0009);
    rdReg(3'd1, v); check(v == 16'h0011, "R3 dev addr frozen", v, 16'h0011);
    rdReg(3'd0, v); check(v == 0, "R3 direction frozen", v, 0);
    rdReg(3'd3, v); check(v == 2, "R3 count frozen", v, 2);
    rdReg(3'd4, v); check(v == 1, "R3 busy", v, 1);
    devReady = 1;
    waitIrq();
    devReady = 0;
    check(memCnt == 2, "R11 restart ignored", memCnt, 2);
    wrReg(3'd4, 16'h0002);
  endtask

  task automatic testZeroCount();
    logic [15:0] v;
    clearCounters();
    wrReg(3'd3, 16'h0000);
    wrReg(3'd0, 16'h0001);
    check(irq == 1, "R9 immediate irq", irq, 1);
    rdReg(3'd4, v); check(v == 2, "R9 status", v, 2);
    repeat (4) @(negedge clk);
    check(reqRise == 0, "R9 no bus request", reqRise, 0);
    wrReg(3'd4, 16'h0002);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testReadback();
    testDevToMem();
    testDoneClear();
    testMemToDev();
    testLockWhileBusy();
    testZeroCount();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual %0d expected below 100000", cycles);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule